// File: doc/BRIEF.md
# Two-Thread Micro-Op Allocator with Per-Thread Caps

This block sits at the entry of an out-of-order core that runs two hardware threads. Each thread presents at most one micro-op at a time, together with a two-bit kind. In every cycle the block grants at most one of the two. The granted micro-op gets a reorder-buffer slot. A load also gets a load-buffer slot, and a store also gets a store-buffer slot. A thread holds its micro-op on the input until that micro-op is granted.

The block keeps one usage counter per thread for each of the three structures. When two threads run, each thread may use at most half of a structure. A thread that cannot fit its pending micro-op is flagged as stalled, and the other thread keeps going. Retirement returns entries through per-thread release counts. When the single-thread mode input is high, the caps no longer apply and one thread can fill the whole of every structure.

Top module: `dual_thread_alloc`

## Requirements
- R1: After reset every usage counter is zero and no thread is stalled. The first cycle in which both threads are eligible grants thread 0, and that grant receives reorder-buffer index 0.
- R2: If both threads are eligible in consecutive grant cycles, the granted thread changes from one cycle to the next.
- R3: If at least one thread is eligible, a grant is made. When the favoured thread is idle or stalled, the other thread is granted in the same cycle.
- R4: With st_mode low, a thread may hold at most 63 reorder, 24 load and 12 store entries. A micro-op that needs a full resource raises that thread's stall bit and is not granted, while the other thread can still be granted.
- R5: With st_mode high, the active thread may hold all 126 reorder, 48 load and 24 store entries, and it stalls only when a whole structure is full.
- R6: With st_mode low, thread t receives indices base+k, where the base is t*63 for the reorder buffer, t*24 for loads and t*12 for stores, and k counts up and wraps within the half. With st_mode high the base is 0 and k wraps at the full size. Kind encoding: 00 plain, 01 load, 10 store, 11 treated as plain. grant_ld_valid and grant_st_valid follow the kind.
- R7: Release counts (two bits per thread, thread 0 in the low bits) are subtracted at the same clock edge at which a grant is added. The room check uses the count held at the start of the cycle, so a release frees space starting from the next cycle.
- R8: A stall bit is high only while that thread's uop_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_mode | input | 1 | 1 = single-thread mode, caps lifted |
| uop_valid | input | 2 | Micro-op pending, one bit per thread |
| uop_kind | input | 4 | Kind per thread, thread 0 in bits [1:0] |
| rel_rob | input | 4 | Reorder entries retired, 2 bits per thread |
| rel_ld | input | 4 | Load entries retired, 2 bits per thread |
| rel_st | input | 4 | Store entries retired, 2 bits per thread |
| stall | output | 2 | Thread cannot fit its pending micro-op |
| grant_valid | output | 1 | A micro-op is granted this cycle |
| grant_thread | output | 1 | Thread that was granted |
| grant_rob_idx | output | 7 | Reorder-buffer index of the grant |
| grant_ld_valid | output | 1 | Grant also takes a load entry |
| grant_ld_idx | output | 6 | Load-buffer index |
| grant_st_valid | output | 1 | Grant also takes a store entry |
| grant_st_idx | output | 5 | Store-buffer index |

## Verification
Some properties are checked by assertions on every cycle. Grants go only to valid, unstalled threads, and no slot is wasted while a thread is eligible. Alternation holds between eligible threads, and stall bits follow uop_valid. A shadow count of reorder usage, rebuilt from grants and releases, stays under the two-thread cap and forces a stall when it reaches the cap. The bench scenarios cover what those checks cannot show: the exact index sequences and where they wrap, the load and store caps, the lifted limits in single-thread mode, and the one-cycle delay before a release makes room.

// File: rtl/dta_pkg.sv
// Shared types for the two-thread allocator.
// Assumes exactly two threads and a two-bit micro-op kind per thread.
package dta_pkg;
    localparam int NT = 2;

    typedef enum logic [1:0] {
        KIND_PLAIN = 2'b00,
        KIND_LOAD  = 2'b01,
        KIND_STORE = 2'b10,
        KIND_RSVD  = 2'b11
    } uop_kind_e;
endpackage

// File: rtl/dta_pick.sv
// Thread picker: serves the favoured thread when it is eligible, otherwise
// the other one. After each grant the favour moves to the other thread.
// Assumes that elig already accounts for valid and resource room.
module dta_pick (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] elig,
    output logic       gnt_v,
    output logic       gnt_t
);
    logic prio;

    // grant whenever anyone is eligible; favour first, else fall back
    always_comb begin
        gnt_v = |elig;
        gnt_t = elig[prio] ? prio : ~prio;
    end

    // hand favour to the thread that did not just win
    always_ff @(posedge clk) begin
        if (!rst_n)     prio <= 1'b0;
        else if (gnt_v) prio <= ~gnt_t;
    end
endmodule

// File: rtl/dta_pool.sv
// One shared structure (reorder, load or store buffer). It keeps a usage
// counter and a ring pointer per thread and reports whether each thread's
// pending need fits. The index comes from the selected thread's ring.
// Assumes that releases never exceed usage and that st_mode changes only
// while the pool is drained.
module dta_pool #(
    parameter int TOTAL = 126,
    parameter int CAP   = 63,
    parameter int RW    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     st_mode,
    input  logic [1:0]               need,
    input  logic [1:0]               take,
    input  logic [2*RW-1:0]          rel,
    input  logic                     sel,
    output logic [1:0]               fits,
    output logic [$clog2(TOTAL)-1:0] idx
);
    localparam int CW = $clog2(TOTAL + 1);
    localparam int IW = $clog2(TOTAL);

    logic [CW-1:0] used_v [2];
    logic [IW-1:0] ptr_v  [2];
    logic [IW-1:0] base_v [2];
    logic [CW:0]   sum;
    logic [CW-1:0] lim;
    logic [IW-1:0] last;

    // limit and ring end for the current mode
    always_comb begin
        sum  = {1'b0, used_v[0]} + {1'b0, used_v[1]};
        lim  = st_mode ? CW'(TOTAL) : CW'(CAP);
        last = st_mode ? IW'(TOTAL - 1) : IW'(CAP - 1);
    end

    for (genvar t = 0; t < 2; t++) begin : g_thr
        logic [CW-1:0] used;
        logic [IW-1:0] ptr;

        assign used_v[t] = used;
        assign ptr_v[t]  = ptr;
        assign base_v[t] = st_mode ? '0 : IW'(t * CAP);
        assign fits[t]   = !need[t] || ((used < lim) && (sum < (CW+1)'(TOTAL)));

        // usage: add this cycle's grant, remove retired entries
        always_ff @(posedge clk) begin
            if (!rst_n) used <= '0;
            else        used <= used - CW'(rel[t*RW +: RW]) + CW'(take[t]);
        end

        // ring pointer advances on each grant and wraps at the mode size
        always_ff @(posedge clk) begin
            if (!rst_n)       ptr <= '0;
            else if (take[t]) ptr <= (ptr == last) ? '0 : ptr + 1'b1;
        end
    end

    // index handed to the granted thread
    assign idx = base_v[sel] + ptr_v[sel];
endmodule

// File: rtl/dual_thread_alloc.sv
// Top of the two-thread allocator. Each cycle at most one micro-op is taken
// from the two thread inputs. It receives a reorder slot and, by kind, a
// load or store slot. Caps apply per thread unless st_mode is high.
// Assumes that each thread holds its micro-op until it is granted.
module dual_thread_alloc
    import dta_pkg::*;
#(
    parameter int ROB_TOTAL = 126,
    parameter int ROB_CAP   = 63,
    parameter int LD_TOTAL  = 48,
    parameter int LD_CAP    = 24,
    parameter int ST_TOTAL  = 24,
    parameter int ST_CAP    = 12,
    parameter int RW        = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         st_mode,
    input  logic [1:0]                   uop_valid,
    input  logic [3:0]                   uop_kind,
    input  logic [2*RW-1:0]              rel_rob,
    input  logic [2*RW-1:0]              rel_ld,
    input  logic [2*RW-1:0]              rel_st,
    output logic [1:0]                   stall,
    output logic                         grant_valid,
    output logic                         grant_thread,
    output logic [$clog2(ROB_TOTAL)-1:0] grant_rob_idx,
    output logic                         grant_ld_valid,
    output logic [$clog2(LD_TOTAL)-1:0]  grant_ld_idx,
    output logic                         grant_st_valid,
    output logic [$clog2(ST_TOTAL)-1:0]  grant_st_idx
);
    logic [1:0] is_ld, is_st;
    logic [1:0] rob_fit, ld_fit, st_fit;
    logic [1:0] elig, take_rob, take_ld, take_st;
    logic       gnt_v, gnt_t;

    for (genvar t = 0; t < NT; t++) begin : g_dec
        assign is_ld[t] = uop_valid[t] && (uop_kind[2*t +: 2] == KIND_LOAD);
        assign is_st[t] = uop_valid[t] && (uop_kind[2*t +: 2] == KIND_STORE);
    end

    // eligibility, stall flags and per-structure take vectors
    always_comb begin
        elig     = uop_valid & rob_fit & ld_fit & st_fit;
        stall    = uop_valid & ~elig;
        take_rob = gnt_v ? (gnt_t ? 2'b10 : 2'b01) : 2'b00;
        take_ld  = take_rob & is_ld;
        take_st  = take_rob & is_st;
    end

    dta_pick pick_i (
        .clk(clk), .rst_n(rst_n), .elig(elig), .gnt_v(gnt_v), .gnt_t(gnt_t)
    );

    dta_pool #(.TOTAL(ROB_TOTAL), .CAP(ROB_CAP), .RW(RW)) rob_i (
        .clk(clk), .rst_n(rst_n), .st_mode(st_mode), .need(uop_valid),
        .take(take_rob), .rel(rel_rob), .sel(gnt_t), .fits(rob_fit),
        .idx(grant_rob_idx)
    );

    dta_pool #(.TOTAL(LD_TOTAL), .CAP(LD_CAP), .RW(RW)) ld_i (
        .clk(clk), .rst_n(rst_n), .st_mode(st_mode), .need(is_ld),
        .take(take_ld), .rel(rel_ld), .sel(gnt_t), .fits(ld_fit),
        .idx(grant_ld_idx)
    );

    dta_pool #(.TOTAL(ST_TOTAL), .CAP(ST_CAP), .RW(RW)) st_i (
        .clk(clk), .rst_n(rst_n), .st_mode(st_mode), .need(is_st),
        .take(take_st), .rel(rel_st), .sel(gnt_t), .fits(st_fit),
        .idx(grant_st_idx)
    );

    // grant outputs
    always_comb begin
        grant_valid    = gnt_v;
        grant_thread   = gnt_t;
        grant_ld_valid = |take_ld;
        grant_st_valid = |take_st;
    end
endmodule

// File: rtl/dta_checker.sv
// Port-level checker for dual_thread_alloc. It rebuilds reorder usage per
// thread from grants and releases and checks arbitration and caps.
// Assumes the same reset and clock as the allocator.
module dta_checker #(
    parameter int ROB_TOTAL = 126,
    parameter int ROB_CAP   = 63,
    parameter int RW        = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         st_mode,
    input logic [1:0]                   uop_valid,
    input logic [2*RW-1:0]              rel_rob,
    input logic [1:0]                   stall,
    input logic                         grant_valid,
    input logic                         grant_thread,
    input logic [$clog2(ROB_TOTAL)-1:0] grant_rob_idx
);
    logic       seen;
    logic [8:0] sh0, sh1;

    // marks that one cycle out of reset has elapsed
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // shadow reorder usage per thread from port activity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh0 <= '0;
            sh1 <= '0;
        end else begin
            sh0 <= sh0 - 9'(rel_rob[RW-1:0])  + 9'(grant_valid && !grant_thread);
            sh1 <= sh1 - 9'(rel_rob[2*RW-1:RW]) + 9'(grant_valid && grant_thread);
        end
    end

    a_r3_grant_valid_thread: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> uop_valid[grant_thread] && !stall[grant_thread]);

    a_r3_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
        (|(uop_valid & ~stall)) |-> grant_valid);

    a_r2_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(grant_valid) && grant_valid && (&uop_valid) && !(|stall))
        |-> grant_thread != $past(grant_thread));

    a_r8_stall_needs_valid0: assert property (@(posedge clk) disable iff (!rst_n)
        !uop_valid[0] |-> !stall[0]);

    a_r8_stall_needs_valid1: assert property (@(posedge clk) disable iff (!rst_n)
        !uop_valid[1] |-> !stall[1]);

    a_r4_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !st_mode |-> (sh0 <= 9'(ROB_CAP)) && (sh1 <= 9'(ROB_CAP)));

    a_r4_stall_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_mode && uop_valid[0] && sh0 == 9'(ROB_CAP)) |-> stall[0]);

    a_r5_total_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (sh0 + sh1) <= 9'(ROB_TOTAL));

    a_r6_rob_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> 32'(grant_rob_idx) < ROB_TOTAL);
endmodule

bind dual_thread_alloc dta_checker #(
    .ROB_TOTAL(ROB_TOTAL), .ROB_CAP(ROB_CAP), .RW(RW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .st_mode(st_mode), .uop_valid(uop_valid),
    .rel_rob(rel_rob), .stall(stall), .grant_valid(grant_valid),
    .grant_thread(grant_thread), .grant_rob_idx(grant_rob_idx)
);

// File: tb/dual_thread_alloc_tb_top.sv
`timescale 1ns/1ps
module dual_thread_alloc_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       st_mode = 1'b0;
    logic [1:0] uop_valid = '0;
    logic [3:0] uop_kind = '0;
    logic [3:0] rel_rob = '0, rel_ld = '0, rel_st = '0;
    logic [1:0] stall;
    logic       grant_valid, grant_thread, grant_ld_valid, grant_st_valid;
    logic [6:0] grant_rob_idx;
    logic [5:0] grant_ld_idx;
    logic [4:0] grant_st_idx;
    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    dual_thread_alloc dut_i (
        .clk(clk), .rst_n(rst_n), .st_mode(st_mode), .uop_valid(uop_valid),
        .uop_kind(uop_kind), .rel_rob(rel_rob), .rel_ld(rel_ld), .rel_st(rel_st),
        .stall(stall), .grant_valid(grant_valid), .grant_thread(grant_thread),
        .grant_rob_idx(grant_rob_idx), .grant_ld_valid(grant_ld_valid),
        .grant_ld_idx(grant_ld_idx), .grant_st_valid(grant_st_valid),
        .grant_st_idx(grant_st_idx)
    );

    // vector: valid[27:26] k0[25:24] k1[23:22] gv[21] th[20] rob[19:13]
    //         ldv[12] ld[11:6] stv[5] st[4:0]; two-thread mode, from reset
    localparam logic [27:0] VEC [10] = '{
        {2'b11, 2'b00, 2'b00, 1'b1, 1'b0, 7'd0,  1'b0, 6'd0,  1'b0, 5'd0},
        {2'b11, 2'b00, 2'b00, 1'b1, 1'b1, 7'd63, 1'b0, 6'd0,  1'b0, 5'd0},
        {2'b10, 2'b00, 2'b01, 1'b1, 1'b1, 7'd64, 1'b1, 6'd24, 1'b0, 5'd0},
        {2'b11, 2'b10, 2'b00, 1'b1, 1'b0, 7'd1,  1'b0, 6'd0,  1'b1, 5'd0},
        {2'b01, 2'b01, 2'b00, 1'b1, 1'b0, 7'd2,  1'b1, 6'd0,  1'b0, 5'd0},
        {2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 7'd0,  1'b0, 6'd0,  1'b0, 5'd0},
        {2'b11, 2'b00, 2'b10, 1'b1, 1'b1, 7'd65, 1'b0, 6'd0,  1'b1, 5'd12},
        {2'b11, 2'b11, 2'b00, 1'b1, 1'b0, 7'd3,  1'b0, 6'd0,  1'b0, 5'd0},
        {2'b11, 2'b00, 2'b00, 1'b1, 1'b1, 7'd66, 1'b0, 6'd0,  1'b0, 5'd0},
        {2'b01, 2'b01, 2'b00, 1'b1, 1'b0, 7'd4,  1'b1, 6'd1,  1'b0, 5'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst_n = 1'b0; st_mode = m; uop_valid = '0; uop_kind = '0;
        rel_rob = '0; rel_ld = '0; rel_st = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive at the falling edge, settle, then the caller samples
    task automatic drive(input logic [1:0] v, input logic [3:0] k, input logic [3:0] rr);
        @(negedge clk);
        uop_valid = v; uop_kind = k; rel_rob = rr;
        #1;
    endtask

    initial begin
        #1ms;
        n_err++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        drive(2'b00, 4'h0, 4'h0);
        chk("R1 stall after reset", stall, 0);
        chk("R1 no grant when idle", grant_valid, 0);

        // table walk: arbitration, fallback and indices (R2 R3 R6)
        for (int i = 0; i < 10; i++) begin
            logic [27:0] e;
            e = VEC[i];
            drive(e[27:26], {e[23:22], e[25:24]}, 4'h0);
            chk("R3 grant_valid", grant_valid, e[21]);
            if (e[21]) begin
                chk("R2 grant_thread", grant_thread, e[20]);
                chk("R6 rob idx", grant_rob_idx, e[19:13]);
                chk("R6 ld valid", grant_ld_valid, e[12]);
                if (e[12]) chk("R6 ld idx", grant_ld_idx, e[11:6]);
                chk("R6 st valid", grant_st_valid, e[5]);
                if (e[5]) chk("R6 st idx", grant_st_idx, e[4:0]);
            end
        end

        // mid-run reset restores thread 0 priority and index 0 (R1)
        do_reset(1'b0);
        drive(2'b11, 4'h0, 4'h0);
        chk("R1 first thread", grant_thread, 0);
        chk("R1 first rob idx", grant_rob_idx, 0);

        // reorder cap in two-thread mode (R4), release timing (R7)
        do_reset(1'b0);
        for (int i = 0; i < 63; i++) begin
            drive(2'b01, 4'h0, 4'h0);
            chk("R4 grant under cap", grant_valid, 1);
            chk("R6 rob ring idx", grant_rob_idx, i);
        end
        drive(2'b01, 4'h0, 4'h0);
        chk("R4 stall at rob cap", stall, 2'b01);
        chk("R4 no grant at cap", grant_valid, 0);
        drive(2'b11, 4'h0, 4'h0);
        chk("R4 other thread proceeds", grant_thread, 1);
        chk("R4 other thread idx", grant_rob_idx, 63);
        chk("R4 capped thread still stalled", stall, 2'b01);
        drive(2'b01, 4'h0, 4'h1);
        chk("R7 release not yet visible", stall, 2'b01);
        drive(2'b01, 4'h0, 4'h0);
        chk("R7 release frees next cycle", grant_valid, 1);
        chk("R6 rob idx wraps in half", grant_rob_idx, 0);
        drive(2'b00, 4'h0, 4'h0);
        chk("R8 no stall without valid", stall, 0);

        // load cap (R4)
        do_reset(1'b0);
        for (int i = 0; i < 24; i++) begin
            drive(2'b01, 4'h1, 4'h0);
            chk("R4 load granted", grant_ld_valid, 1);
            chk("R6 load idx", grant_ld_idx, i);
        end
        drive(2'b01, 4'h1, 4'h0);
        chk("R4 stall at load cap", stall, 2'b01);
        drive(2'b11, 4'h5, 4'h0);
        chk("R4 t1 load while t0 capped", grant_thread, 1);
        chk("R6 t1 load idx", grant_ld_idx, 24);

        // store cap (R4)
        do_reset(1'b0);
        for (int i = 0; i < 12; i++) begin
            drive(2'b01, 4'h2, 4'h0);
            chk("R6 store idx", grant_st_idx, i);
        end
        drive(2'b01, 4'h2, 4'h0);
        chk("R4 stall at store cap", stall, 2'b01);

        // single-thread mode: full reorder buffer (R5)
        do_reset(1'b1);
        for (int i = 0; i < 126; i++) begin
            drive(2'b01, 4'h0, 4'h0);
            chk("R5 grant past half", grant_valid, 1);
            chk("R6 full ring idx", grant_rob_idx, i);
        end
        drive(2'b01, 4'h0, 4'h0);
        chk("R5 stall when rob full", stall, 2'b01);

        // single-thread mode: full load buffer (R5)
        do_reset(1'b1);
        for (int i = 0; i < 48; i++) begin
            drive(2'b01, 4'h1, 4'h0);
            chk("R5 load idx", grant_ld_idx, i);
        end
        drive(2'b01, 4'h1, 4'h0);
        chk("R5 stall when load full", stall, 2'b01);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule